// File: doc/BRIEF.md
# Memory-Card Receive Data Path

This block is the receive half of a memory-card host data path. It watches one serial data line, sampled on strobes of the card bit clock, and packs the arriving bits into bytes that it hands to a receive FIFO one byte per write pulse. A transfer is started from software-side control logic with a total byte count. It runs in one of two modes. In block mode, each block opens with a start bit, carries a programmable number of bytes and closes with a 16-bit CRC. In stream mode, a single start bit is followed by raw bytes until the count runs out.

Between blocks the controller sits in a wait-for-receive state with a bit-clock timeout running. It can instead park in a read-wait state, where the timeout is frozen, until a stop request arrives. Every error or abort ends in idle, and only once the FIFO has drained. Whether a CRC failure ends at once or later, and whether an abort is honoured at all, depends on how much of the transfer is left.

Top module: `card_rx_datapath`

## Requirements
- R1: Bits are packed MSB first. The edge that samples the eighth bit of a byte raises `fifo_wr` for exactly one cycle in the next cycle, with the byte on `fifo_data`.
- R2: In block mode, a 0 on the line while in wait-for-receive starts a block. The block holds `blk_bytes` data bytes, or fewer if the remaining count runs out first, followed by 16 CRC bits sent MSB first. The CRC is CRC-16 with polynomial 0x1021 and initial value 0, computed over the data bits of the block.
- R3: When the CRC matches and `rw_start` is 0, `flag_blkend` is set and the state becomes wait-for-receive with the timeout reloaded. Wait-for-receive with a remaining count of zero goes to idle on the next cycle.
- R4: When the CRC matches, `rw_start` is 1 and bytes remain, `flag_blkend` is set and the state becomes read-wait. The timeout does not run in read-wait. `rw_stop` in read-wait moves the state to wait-for-receive and reloads the timeout.
- R5: When the CRC mismatches and bytes remain, `flag_crcfail` is set at once. The state stays receive, and no further bytes are written. The state goes to idle once `fifo_empty` is 1 and no write is in flight.
- R6: When the CRC mismatches and the remaining count is zero, the state goes to drain. `flag_crcfail` is set only when the drain ends in idle, and that happens once the FIFO is empty.
- R7: In stream mode there is no CRC. After the last byte the state goes to wait-for-receive and then to idle, and `flag_blkend` stays 0.
- R8: A byte completed while `fifo_full` is 1 is dropped, `flag_overrun` is set, and reception stops with the state held at receive. The state goes to idle once the FIFO is empty.
- R9: `tmo_load` = N is loaded at start and at each reload. In wait-for-receive, the (N+1)th consecutive sampled 1 sets `flag_timeout` and moves the state to drain, which ends in idle when the FIFO is empty.
- R10: An abort in wait-for-receive, receive or read-wait that comes before the last two data bits of the transfer does three things. It writes any partial byte, left-justified and zero-filled, to the FIFO. It moves the state to drain. It sets `flag_abort` when the drain ends in idle.
- R11: An abort that comes once six or more bits of the final byte have been sampled, or after the count has reached zero, is ignored. The transfer then completes normally and `flag_abort` stays 0.
- R12: After reset and at each start, all flags are 0. After reset, `fifo_wr` is 0. `state_o` encodes the states as idle=0, wait-for-receive=1, receive=2, read-wait=3 and drain=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Card bit-clock sample strobe |
| rx_bit | input | 1 | Serial data line |
| start | input | 1 | Begin a transfer (honoured in idle) |
| stream_mode | input | 1 | 1 = stream, 0 = block (latched at start) |
| blk_bytes | input | BLKW | Bytes per block |
| total_bytes | input | CNTW | Bytes in the whole transfer |
| rw_start | input | 1 | Enter read-wait after a good block |
| rw_stop | input | 1 | Leave read-wait |
| abort_req | input | 1 | Abort strobe |
| tmo_load | input | TOW | Timeout reload value in bit periods |
| fifo_empty | input | 1 | Receive FIFO empty |
| fifo_full | input | 1 | Receive FIFO full |
| fifo_wr | output | 1 | FIFO write pulse |
| fifo_data | output | DW | FIFO write data |
| flag_blkend | output | 1 | A block passed its CRC |
| flag_crcfail | output | 1 | CRC mismatch |
| flag_overrun | output | 1 | Byte lost to a full FIFO |
| flag_timeout | output | 1 | No start bit within the timeout |
| flag_abort | output | 1 | Transfer was aborted |
| state_o | output | 3 | Current state |

## Verification
Block reception is driven with a two-block transfer and a good CRC, and again with a corrupted CRC both mid-transfer and on the final block. This separates the immediate-fail path from the deferred-fail path. A read-wait run with high idle bits shows that the timeout is frozen there. A timeout run is sampled one bit before and at expiry, which pins the N+1 count. Stream runs cover a clean end, an overrun halfway through, and aborts at three and at six bits into the last byte, which places the boundary of the abort window.

// File: rtl/crx_pkg.sv
package crx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WAITR = 3'd1,
    ST_RECV  = 3'd2,
    ST_RWAIT = 3'd3,
    ST_DRAIN = 3'd4
  } crx_state_e;

  localparam logic [15:0] CRX_POLY = 16'h1021;
  localparam int          CRX_CRCW = 16;
endpackage

// File: rtl/crx_shifter.sv
module crx_shifter #(
  parameter int DW = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    shift_en,
  input  logic                    bit_in,
  output logic [DW-1:0]           byte_now,
  output logic [$clog2(DW)-1:0]   bit_cnt,
  output logic                    byte_done,
  output logic [DW-1:0]           flush_byte
);
  localparam int BCW = $clog2(DW);

  logic [DW-2:0]  sr_q;
  logic [BCW-1:0] cnt_q;
  logic [DW-1:0]  ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (shift_en) begin
      sr_q  <= {sr_q[DW-3:0], bit_in};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    bit_cnt    = cnt_q;
    byte_done  = shift_en && (cnt_q == BCW'(DW-1));
    byte_now   = {sr_q, bit_in};
    ext        = {sr_q, 1'b0};
    flush_byte = ext << (BCW'(DW-1) - cnt_q);
  end
endmodule

// File: rtl/crx_crc.sv
module crx_crc #(
  parameter int          W    = 16,
  parameter logic [W-1:0] POLY = 16'h1021
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output logic nxt_zero
);
  logic [W-1:0] crc_q;
  logic [W-1:0] crc_d;
  logic         fb;

  always_comb begin
    fb       = crc_q[W-1] ^ bit_in;
    crc_d    = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    nxt_zero = (crc_d == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '0;
    else if (clr)   crc_q <= '0;
    else if (en)    crc_q <= crc_d;
  end
endmodule

// File: rtl/crx_timer.sv
module crx_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  output logic         expired
);
  logic [W-1:0] cnt_q;

  always_comb expired = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= load_val;
    else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/card_rx_datapath.sv
module card_rx_datapath
  import crx_pkg::*;
#(
  parameter int DW   = 8,
  parameter int CNTW = 16,
  parameter int BLKW = 12,
  parameter int TOW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            rx_bit,
  input  logic            start,
  input  logic            stream_mode,
  input  logic [BLKW-1:0] blk_bytes,
  input  logic [CNTW-1:0] total_bytes,
  input  logic            rw_start,
  input  logic            rw_stop,
  input  logic            abort_req,
  input  logic [TOW-1:0]  tmo_load,
  input  logic            fifo_empty,
  input  logic            fifo_full,
  output logic            fifo_wr,
  output logic [DW-1:0]   fifo_data,
  output logic            flag_blkend,
  output logic            flag_crcfail,
  output logic            flag_overrun,
  output logic            flag_timeout,
  output logic            flag_abort,
  output logic [2:0]      state_o
);
  localparam int BCW = $clog2(DW);
  localparam int CCW = $clog2(CRX_CRCW);

  crx_state_e      state_q, state_d;
  logic [CNTW-1:0] rem_q, rem_d;
  logic [BLKW-1:0] blk_q, blk_d;
  logic            crcph_q, crcph_d;
  logic [CCW-1:0]  ccnt_q, ccnt_d;
  logic            blocked_q, blocked_d;
  logic            pabort_q, pabort_d;
  logic            pcrc_q, pcrc_d;
  logic            stream_q, stream_d;
  logic            wr_q, wr_d;
  logic [DW-1:0]   data_q, data_d;
  logic            f_blk_q, f_blk_d;
  logic            f_crc_q, f_crc_d;
  logic            f_ovr_q, f_ovr_d;
  logic            f_tmo_q, f_tmo_d;
  logic            f_abt_q, f_abt_d;

  logic            sh_clr, sh_en, crc_clr, crc_en, tm_load, tm_tick;
  logic [DW-1:0]   byte_now, flush_byte;
  logic [BCW-1:0]  bit_cnt;
  logic            byte_done, crc_ok, tm_expired;
  logic            late, drained, abort_hit;

  crx_shifter #(.DW(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en), .bit_in(rx_bit),
    .byte_now(byte_now), .bit_cnt(bit_cnt), .byte_done(byte_done),
    .flush_byte(flush_byte)
  );

  crx_crc #(.W(CRX_CRCW), .POLY(CRX_POLY)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .en(crc_en), .bit_in(rx_bit),
    .nxt_zero(crc_ok)
  );

  crx_timer #(.W(TOW)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(tm_load), .load_val(tmo_load),
    .tick(tm_tick), .expired(tm_expired)
  );

  always_comb begin
    late      = (rem_q == '0) ||
                (state_q == ST_RECV && !crcph_q && rem_q == CNTW'(1) &&
                 bit_cnt >= BCW'(DW-2));
    drained   = fifo_empty && !wr_q;
    abort_hit = abort_req && !late &&
                (state_q == ST_WAITR || state_q == ST_RECV || state_q == ST_RWAIT);
  end

  // next-state logic
  always_comb begin
    state_d   = state_q;
    rem_d     = rem_q;
    blk_d     = blk_q;
    crcph_d   = crcph_q;
    ccnt_d    = ccnt_q;
    blocked_d = blocked_q;
    pabort_d  = pabort_q;
    pcrc_d    = pcrc_q;
    stream_d  = stream_q;
    wr_d      = 1'b0;
    data_d    = data_q;
    f_blk_d   = f_blk_q;
    f_crc_d   = f_crc_q;
    f_ovr_d   = f_ovr_q;
    f_tmo_d   = f_tmo_q;
    f_abt_d   = f_abt_q;
    sh_clr    = 1'b0;
    sh_en     = 1'b0;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    tm_load   = 1'b0;
    tm_tick   = 1'b0;

    if (abort_hit) begin
      if (state_q == ST_RECV && !blocked_q && !crcph_q && bit_cnt != '0) begin
        if (fifo_full) f_ovr_d = 1'b1;
        else begin
          wr_d   = 1'b1;
          data_d = flush_byte;
        end
      end
      state_d   = ST_DRAIN;
      pabort_d  = 1'b1;
      blocked_d = 1'b0;
      crcph_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_d   = ST_WAITR;
            rem_d     = total_bytes;
            stream_d  = stream_mode;
            blocked_d = 1'b0;
            pabort_d  = 1'b0;
            pcrc_d    = 1'b0;
            crcph_d   = 1'b0;
            f_blk_d   = 1'b0;
            f_crc_d   = 1'b0;
            f_ovr_d   = 1'b0;
            f_tmo_d   = 1'b0;
            f_abt_d   = 1'b0;
            tm_load   = 1'b1;
            sh_clr    = 1'b1;
          end
        end

        ST_WAITR: begin
          if (rem_q == '0) begin
            state_d = ST_IDLE;
          end else if (bit_en) begin
            if (!rx_bit) begin
              state_d = ST_RECV;
              blk_d   = blk_bytes;
              crcph_d = 1'b0;
              ccnt_d  = '0;
              sh_clr  = 1'b1;
              crc_clr = 1'b1;
            end else begin
              tm_tick = 1'b1;
              if (tm_expired) begin
                f_tmo_d = 1'b1;
                state_d = ST_DRAIN;
              end
            end
          end
        end

        ST_RECV: begin
          if (blocked_q) begin
            if (drained) begin
              state_d   = ST_IDLE;
              blocked_d = 1'b0;
            end
          end else if (bit_en) begin
            if (!crcph_q) begin
              sh_en  = 1'b1;
              crc_en = !stream_q;
              if (byte_done) begin
                if (fifo_full) begin
                  f_ovr_d   = 1'b1;
                  blocked_d = 1'b1;
                end else begin
                  wr_d   = 1'b1;
                  data_d = byte_now;
                  rem_d  = rem_q - 1'b1;
                  blk_d  = blk_q - 1'b1;
                  if (stream_q) begin
                    if (rem_q == CNTW'(1)) state_d = ST_WAITR;
                  end else if (rem_q == CNTW'(1) || blk_q == BLKW'(1)) begin
                    crcph_d = 1'b1;
                    ccnt_d  = '0;
                  end
                end
              end
            end else begin
              crc_en = 1'b1;
              ccnt_d = ccnt_q + 1'b1;
              if (ccnt_q == CCW'(CRX_CRCW-1)) begin
                crcph_d = 1'b0;
                if (crc_ok) begin
                  f_blk_d = 1'b1;
                  if (rw_start && rem_q != '0) begin
                    state_d = ST_RWAIT;
                  end else begin
                    state_d = ST_WAITR;
                    tm_load = 1'b1;
                  end
                end else if (rem_q != '0) begin
                  f_crc_d   = 1'b1;
                  blocked_d = 1'b1;
                end else begin
                  state_d = ST_DRAIN;
                  pcrc_d  = 1'b1;
                end
              end
            end
          end
        end

        ST_RWAIT: begin
          if (rw_stop) begin
            state_d = ST_WAITR;
            tm_load = 1'b1;
          end
        end

        ST_DRAIN: begin
          if (drained) begin
            state_d  = ST_IDLE;
            f_abt_d  = f_abt_q | pabort_q;
            f_crc_d  = f_crc_q | pcrc_q;
            pabort_d = 1'b0;
            pcrc_d   = 1'b0;
          end
        end

        default: state_d = ST_IDLE;
      endcase
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      rem_q     <= '0;
      blk_q     <= '0;
      crcph_q   <= 1'b0;
      ccnt_q    <= '0;
      blocked_q <= 1'b0;
      pabort_q  <= 1'b0;
      pcrc_q    <= 1'b0;
      stream_q  <= 1'b0;
      wr_q      <= 1'b0;
      data_q    <= '0;
      f_blk_q   <= 1'b0;
      f_crc_q   <= 1'b0;
      f_ovr_q   <= 1'b0;
      f_tmo_q   <= 1'b0;
      f_abt_q   <= 1'b0;
    end else begin
      state_q   <= state_d;
      rem_q     <= rem_d;
      blk_q     <= blk_d;
      crcph_q   <= crcph_d;
      ccnt_q    <= ccnt_d;
      blocked_q <= blocked_d;
      pabort_q  <= pabort_d;
      pcrc_q    <= pcrc_d;
      stream_q  <= stream_d;
      wr_q      <= wr_d;
      data_q    <= data_d;
      f_blk_q   <= f_blk_d;
      f_crc_q   <= f_crc_d;
      f_ovr_q   <= f_ovr_d;
      f_tmo_q   <= f_tmo_d;
      f_abt_q   <= f_abt_d;
    end
  end

  assign fifo_wr      = wr_q;
  assign fifo_data    = data_q;
  assign flag_blkend  = f_blk_q;
  assign flag_crcfail = f_crc_q;
  assign flag_overrun = f_ovr_q;
  assign flag_timeout = f_tmo_q;
  assign flag_abort   = f_abt_q;
  assign state_o      = state_q;
endmodule

// File: rtl/crx_checker.sv
module crx_checker
  import crx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state,
  input logic       fifo_wr,
  input logic       fifo_full,
  input logic       flag_blkend,
  input logic       flag_crcfail,
  input logic       flag_timeout,
  input logic       flag_abort
);
  // R1: a write strobe never lasts two cycles
  assert_wr_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |=> !fifo_wr);

  // R8: no write is issued on a cycle that saw the FIFO full
  assert_no_wr_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !$past(fifo_full));

  // R3: a good block lands in wait-for-receive or read-wait
  assert_blkend_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_blkend) |-> (state == 3'(ST_WAITR) || state == 3'(ST_RWAIT)));

  // R4: read-wait is only entered from receive
  assert_rwait_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'(ST_RWAIT) && $past(state) != 3'(ST_RWAIT)) |-> $past(state) == 3'(ST_RECV));

  // R5: CRC failure appears either while held in receive or on the drain exit
  assert_crcfail_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_crcfail) |-> (state == 3'(ST_RECV) || state == 3'(ST_IDLE)));

  // R9: timeout is raised together with the move to drain
  assert_timeout_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_timeout) |-> state == 3'(ST_DRAIN));

  // R10: abort flag appears only on reaching idle
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_abort) |-> state == 3'(ST_IDLE));

  // R12: only the five defined encodings occur
  assert_state_legal_R12: assert property (@(posedge clk) disable iff (!rst_n)
    state <= 3'(ST_DRAIN));
endmodule

bind card_rx_datapath crx_checker chk_i (
  .clk(clk), .rst_n(rst_n), .state(state_o), .fifo_wr(fifo_wr),
  .fifo_full(fifo_full), .flag_blkend(flag_blkend), .flag_crcfail(flag_crcfail),
  .flag_timeout(flag_timeout), .flag_abort(flag_abort)
);

// File: tb/card_rx_datapath_tb_top.sv
`timescale 1ns/1ps
module card_rx_datapath_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_en, rx_bit, start, stream_mode, rw_start, rw_stop, abort_req;
  logic [11:0] blk_bytes;
  logic [15:0] total_bytes, tmo_load;
  logic        fifo_empty, fifo_full;
  logic        fifo_wr;
  logic [7:0]  fifo_data;
  logic        flag_blkend, flag_crcfail, flag_overrun, flag_timeout, flag_abort;
  logic [2:0]  state_o;

  int checks = 0;
  int fails  = 0;
  int wr_seen = 0;
  bit done = 0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  card_rx_datapath dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit), .start(start),
    .stream_mode(stream_mode), .blk_bytes(blk_bytes), .total_bytes(total_bytes),
    .rw_start(rw_start), .rw_stop(rw_stop), .abort_req(abort_req),
    .tmo_load(tmo_load), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .flag_blkend(flag_blkend),
    .flag_crcfail(flag_crcfail), .flag_overrun(flag_overrun),
    .flag_timeout(flag_timeout), .flag_abort(flag_abort), .state_o(state_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write (R1)
  always @(negedge clk) begin
    if (rst_n === 1'b1 && fifo_wr === 1'b1) begin
      wr_seen++;
      if (exp_q.size() == 0) chk("R1 unexpected write", int'(fifo_data), -1);
      else chk("R1 write data", int'(fifo_data), int'(exp_q.pop_front()));
    end
  end

  function automatic logic [15:0] crc2(input logic [7:0] b0, input logic [7:0] b1);
    logic [15:0] c = 16'h0000;
    logic [7:0]  bs [2];
    bs[0] = b0; bs[1] = b1;
    for (int k = 0; k < 2; k++) begin
      c = c ^ {bs[k], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic send_bit(input logic b);
    rx_bit = b; bit_en = 1'b1;
    @(negedge clk);
    bit_en = 1'b0; rx_bit = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit expect_wr);
    if (expect_wr) exp_q.push_back(v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_crc(input logic [15:0] c);
    for (int i = 15; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic pulse_start(input logic smode, input logic [15:0] tot, input logic [11:0] blk);
    stream_mode = smode; total_bytes = tot; blk_bytes = blk;
    start = 1'b1; @(negedge clk); start = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int w0;
    rst_n = 1'b0; bit_en = 0; rx_bit = 1; start = 0; stream_mode = 0;
    rw_start = 0; rw_stop = 0; abort_req = 0; blk_bytes = 12'd2;
    total_bytes = 16'd0; tmo_load = 16'd100; fifo_empty = 1; fifo_full = 0;
    idle_cycles(3);
    rst_n = 1'b1;
    idle_cycles(1);

    // R12 reset state
    chk("R12 reset state", state_o, 0);
    chk("R12 reset flags", {flag_blkend, flag_crcfail, flag_overrun, flag_timeout, flag_abort}, 0);
    chk("R12 reset fifo_wr", fifo_wr, 0);

    // R2/R3: two good blocks
    pulse_start(1'b0, 16'd4, 12'd2);
    chk("R12 start enters wait", state_o, 1);
    send_bit(1'b0);
    send_byte(8'h3C, 1); send_byte(8'hA5, 1);
    send_crc(crc2(8'h3C, 8'hA5));
    chk("R3 good block to wait", state_o, 1);
    chk("R3 blkend set", flag_blkend, 1);
    send_bit(1'b0);
    send_byte(8'h01, 1); send_byte(8'hFE, 1);
    send_crc(crc2(8'h01, 8'hFE));
    chk("R2 transfer ends idle", state_o, 0);
    chk("R2 no crcfail on good data", flag_crcfail, 0);
    chk("R2 scoreboard drained", exp_q.size(), 0);

    // R5: bad CRC with data outstanding
    fifo_empty = 0;
    pulse_start(1'b0, 16'd4, 12'd2);
    chk("R12 start clears blkend", flag_blkend, 0);
    send_bit(1'b0);
    send_byte(8'h3C, 1); send_byte(8'hA5, 1);
    send_crc(crc2(8'h3C, 8'hA5) ^ 16'h0001);
    chk("R5 crcfail immediate", flag_crcfail, 1);
    chk("R5 stays receive", state_o, 2);
    w0 = wr_seen;
    send_bit(1'b0); send_byte(8'h55, 0);
    chk("R5 no writes while blocked", wr_seen, w0);
    chk("R5 still receive", state_o, 2);
    fifo_empty = 1; idle_cycles(2);
    chk("R5 idle after drain", state_o, 0);

    // R6: bad CRC at count zero
    fifo_empty = 0;
    pulse_start(1'b0, 16'd2, 12'd2);
    send_bit(1'b0);
    send_byte(8'h77, 1); send_byte(8'h88, 1);
    send_crc(crc2(8'h77, 8'h88) ^ 16'h8000);
    chk("R6 drain state", state_o, 4);
    chk("R6 crcfail deferred", flag_crcfail, 0);
    fifo_empty = 1; idle_cycles(2);
    chk("R6 idle after drain", state_o, 0);
    chk("R6 crcfail on exit", flag_crcfail, 1);

    // R4: read-wait
    rw_start = 1; tmo_load = 16'd2;
    pulse_start(1'b0, 16'd4, 12'd2);
    send_bit(1'b0);
    send_byte(8'hC1, 1); send_byte(8'h2D, 1);
    send_crc(crc2(8'hC1, 8'h2D));
    chk("R4 read-wait entered", state_o, 3);
    chk("R4 blkend set", flag_blkend, 1);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    chk("R4 timer frozen", flag_timeout, 0);
    chk("R4 still read-wait", state_o, 3);
    rw_stop = 1; @(negedge clk); rw_stop = 0;
    chk("R4 stop to wait", state_o, 1);
    rw_start = 0;
    send_bit(1'b0);
    send_byte(8'h9A, 1); send_byte(8'hBC, 1);
    send_crc(crc2(8'h9A, 8'hBC));
    chk("R4 transfer completes", state_o, 0);
    chk("R4 no timeout", flag_timeout, 0);

    // R9: timeout N+1
    tmo_load = 16'd3;
    pulse_start(1'b0, 16'd2, 12'd2);
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    chk("R9 no timeout at N", flag_timeout, 0);
    chk("R9 still wait at N", state_o, 1);
    send_bit(1'b1);
    chk("R9 timeout at N+1", flag_timeout, 1);
    chk("R9 idle after drain", state_o, 0);
    tmo_load = 16'd100;

    // R7: stream
    pulse_start(1'b1, 16'd3, 12'd2);
    send_bit(1'b0);
    send_byte(8'h11, 1); send_byte(8'h22, 1); send_byte(8'h33, 1);
    chk("R7 stream ends idle", state_o, 0);
    chk("R7 no blkend in stream", flag_blkend, 0);
    chk("R7 scoreboard drained", exp_q.size(), 0);

    // R8: overrun
    fifo_empty = 0;
    pulse_start(1'b1, 16'd3, 12'd2);
    send_bit(1'b0);
    send_byte(8'h44, 1);
    fifo_full = 1;
    send_byte(8'h55, 0);
    chk("R8 overrun flag", flag_overrun, 1);
    chk("R8 stays receive", state_o, 2);
    fifo_full = 0;
    w0 = wr_seen;
    send_byte(8'h66, 0);
    chk("R8 no writes after overrun", wr_seen, w0);
    fifo_empty = 1; idle_cycles(2);
    chk("R8 idle after drain", state_o, 0);

    // R10: early abort with partial byte 101 -> A0
    fifo_empty = 0;
    pulse_start(1'b1, 16'd2, 12'd2);
    send_bit(1'b0);
    send_byte(8'h12, 1);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    exp_q.push_back(8'hA0);
    abort_req = 1; @(negedge clk); abort_req = 0;
    chk("R10 drain state", state_o, 4);
    chk("R10 abort deferred", flag_abort, 0);
    fifo_empty = 1; idle_cycles(2);
    chk("R10 idle after drain", state_o, 0);
    chk("R10 abort flag", flag_abort, 1);
    chk("R10 flush written", exp_q.size(), 0);

    // R11: late abort after six bits of last byte
    pulse_start(1'b1, 16'd2, 12'd2);
    send_bit(1'b0);
    send_byte(8'h0F, 1);
    exp_q.push_back(8'hC3);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
    send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
    abort_req = 1; @(negedge clk); abort_req = 0;
    chk("R11 abort ignored", state_o, 2);
    send_bit(1'b1); send_bit(1'b1);
    chk("R11 completes idle", state_o, 0);
    chk("R11 no abort flag", flag_abort, 0);
    chk("R11 last byte written", exp_q.size(), 0);

    idle_cycles(4);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule